// File: doc/BRIEF.md
# Dual-Clock Shift and Storage Register

This block takes a serial bit stream and turns it into a parallel word in two stages. A shift register accepts one bit per rising edge of its own clock. A separate storage register is loaded from every shift stage on a rising edge of a second clock, and it drives the parallel outputs. Because of this split, a new word can be shifted in while the previous word stays on the outputs.

Each register has its own active-low reset, and the reset acts asynchronously. The top shift stage is also brought out as a serial output, so several instances can be chained into a wider converter. The register width is a parameter with a default of 8.

Top module: `dual_clk_sreg`

## Requirements
- R1: On a rising `sh_clk` edge with `sh_rst_n` high, stage 0 takes `ser_in` and each stage n takes the old value of stage n-1.
- R2: `ser_out` always equals the most significant shift stage. After a shift it therefore shows the value that stage W-2 held before that shift.
- R3: While `sh_rst_n` is low, every shift stage is zero and `ser_out` is low. The reset takes effect without a clock edge, and `par_out` keeps its value.
- R4: While `st_rst_n` is low, `par_out` is all zeros. The reset takes effect without a clock edge, and neither the shift stages nor `ser_out` change.
- R5: On a rising `st_clk` edge with `st_rst_n` high, `par_out` takes all W shift stages, with bit n equal to stage n.
- R6: A rising `st_clk` edge while `sh_rst_n` is low and `st_rst_n` is high loads zeros, so `par_out` becomes all low.
- R7: When `sh_clk` and `st_clk` rise in the same instant, `par_out` takes the shift contents from before that shift.
- R8: A `sh_clk` edge that falls strictly between two `st_clk` edges leaves `par_out` unchanged. When `sh_clk` rises before `st_clk`, the following storage edge captures the contents after the shift.
- R9: A bit entered at `ser_in` appears on `ser_out` after exactly W shift edges, which is what allows instances to be cascaded.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| ser_in | input | 1 | Serial data, sampled on the rising edge of sh_clk |
| sh_clk | input | 1 | Shift register clock |
| st_clk | input | 1 | Storage register clock |
| sh_rst_n | input | 1 | Asynchronous clear of the shift register, active low |
| st_rst_n | input | 1 | Asynchronous clear of the storage register, active low |
| par_out | output | W | Storage register contents |
| ser_out | output | 1 | Most significant shift stage, used for cascading |

## Verification
The checker assumes that `ser_in` is stable around each rising edge of `sh_clk`. It also assumes that a clock edge coinciding with a reset release is never judged on its own. The bench only changes `ser_in` while both clocks are low and at least 5 ns away from any edge, and it releases resets only while the clocks are low. Same-instant edges are created by raising both clocks in one time step. Skewed edges are spaced 2 ns apart, so each clock's capture takes place in a well-defined order.

// File: rtl/sreg_pkg.sv
package sreg_pkg;
   localparam int unsigned SREG_MIN_W = 2;
   localparam int unsigned SREG_MAX_W = 1024;

   function automatic bit sreg_width_ok(input int unsigned w);
      return (w >= SREG_MIN_W) && (w <= SREG_MAX_W);
   endfunction
endpackage

// File: rtl/sreg_shift_chain.sv
module sreg_shift_chain
   import sreg_pkg::*;
#(
   parameter int unsigned W = 8
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         din,
   output logic [W-1:0] q
);
   localparam int unsigned LAST = W - 1;

   if (!sreg_width_ok(W)) begin : g_bad_width
      $error("sreg_shift_chain: width %0d outside supported range", W);
   end

   for (genvar i = 0; i <= LAST; i++) begin : g_stage
      logic bit_q;
      logic bit_d;
      if (i == 0) begin : g_head
         assign bit_d = din;
      end else begin : g_body
         assign bit_d = q[i-1];
      end
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) bit_q <= 1'b0;
         else        bit_q <= bit_d;
      end
      assign q[i] = bit_q;
   end
endmodule

// File: rtl/sreg_hold_bank.sv
module sreg_hold_bank
   import sreg_pkg::*;
#(
   parameter int unsigned W = 8
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] d,
   output logic [W-1:0] q
);
   if (!sreg_width_ok(W)) begin : g_bad_width
      $error("sreg_hold_bank: width %0d outside supported range", W);
   end

   for (genvar i = 0; i < W; i++) begin : g_bit
      logic bit_q;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) bit_q <= 1'b0;
         else        bit_q <= d[i];
      end
      assign q[i] = bit_q;
   end
endmodule

// File: rtl/sreg_serial_tap.sv
module sreg_serial_tap #(
   parameter int unsigned W = 8
) (
   input  logic [W-1:0] stages,
   output logic         tap
);
   localparam int unsigned TOP = W - 1;
   assign tap = stages[TOP];
endmodule

// File: rtl/dual_clk_sreg.sv
module dual_clk_sreg
   import sreg_pkg::*;
#(
   parameter int unsigned W = 8
) (
   input  logic         ser_in,
   input  logic         sh_clk,
   input  logic         st_clk,
   input  logic         sh_rst_n,
   input  logic         st_rst_n,
   output logic [W-1:0] par_out,
   output logic         ser_out
);
   if (!sreg_width_ok(W)) begin : g_bad_width
      $error("dual_clk_sreg: width %0d outside supported range", W);
   end

   logic [W-1:0] shift_q;

   sreg_shift_chain #(.W(W)) u_chain (
      .clk   (sh_clk),
      .rst_n (sh_rst_n),
      .din   (ser_in),
      .q     (shift_q)
   );

   sreg_hold_bank #(.W(W)) u_hold (
      .clk   (st_clk),
      .rst_n (st_rst_n),
      .d     (shift_q),
      .q     (par_out)
   );

   sreg_serial_tap #(.W(W)) u_tap (
      .stages (shift_q),
      .tap    (ser_out)
   );
endmodule

// File: rtl/dual_clk_sreg_chk.sv
module dual_clk_sreg_chk #(
   parameter int unsigned W = 8
) (
   input logic         ser_in,
   input logic         sh_clk,
   input logic         st_clk,
   input logic         sh_rst_n,
   input logic         st_rst_n,
   input logic [W-1:0] par_out,
   input logic         ser_out,
   input logic [W-1:0] sh_q
);
   logic         sh_seen;
   logic [W-1:0] sh_prev;
   logic         din_prev;
   logic         st_seen;
   logic [W-1:0] st_prev;

   always_ff @(posedge sh_clk or negedge sh_rst_n) begin
      if (!sh_rst_n) begin
         sh_seen  <= 1'b0;
         sh_prev  <= '0;
         din_prev <= 1'b0;
      end else begin
         sh_seen  <= 1'b1;
         sh_prev  <= sh_q;
         din_prev <= ser_in;
      end
   end

   always_ff @(posedge st_clk or negedge st_rst_n) begin
      if (!st_rst_n) begin
         st_seen <= 1'b0;
         st_prev <= '0;
      end else begin
         st_seen <= 1'b1;
         st_prev <= sh_q;
      end
   end

   AST_SHIFT_MOVE: assert property (@(negedge sh_clk) disable iff (!sh_rst_n)
      sh_seen |-> (sh_q == {sh_prev[W-2:0], din_prev})); // R1
   AST_SER_TAP: assert property (@(negedge sh_clk) disable iff (!sh_rst_n)
      ser_out == sh_q[W-1]); // R2
   AST_SH_CLEAR: assert property (@(negedge sh_clk)
      !sh_rst_n |-> (ser_out == 1'b0)); // R3
   AST_ST_CLEAR: assert property (@(negedge st_clk)
      !st_rst_n |-> (par_out == '0)); // R4
   AST_XFER: assert property (@(negedge st_clk) disable iff (!st_rst_n)
      st_seen |-> (par_out == st_prev)); // R7
endmodule

bind dual_clk_sreg dual_clk_sreg_chk #(.W(W)) u_chk (
   .ser_in   (ser_in),
   .sh_clk   (sh_clk),
   .st_clk   (st_clk),
   .sh_rst_n (sh_rst_n),
   .st_rst_n (st_rst_n),
   .par_out  (par_out),
   .ser_out  (ser_out),
   .sh_q     (shift_q)
);

// File: tb/tb_dual_clk_sreg.sv
module tb_dual_clk_sreg;
   localparam int unsigned W      = 8;
   localparam int unsigned PERIOD = 10;   // 100 MHz
   localparam int unsigned HALF   = PERIOD / 2;
   // op: 2'b00 shift only, 2'b01 store only, 2'b10 both in the same instant
   localparam int NV = 24;
   localparam logic [2:0] VEC [NV] = '{
      3'b00_1, 3'b00_0, 3'b00_1, 3'b00_1, 3'b00_0, 3'b00_0, 3'b00_1, 3'b00_0,
      3'b01_0, 3'b00_1, 3'b10_1, 3'b10_0, 3'b00_0, 3'b01_1, 3'b10_1, 3'b00_1,
      3'b00_0, 3'b10_0, 3'b00_1, 3'b01_0, 3'b10_1, 3'b00_0, 3'b00_1, 3'b01_1
   };

   logic         ser_in, sh_clk, st_clk, sh_rst_n, st_rst_n;
   logic [W-1:0] par_out;
   logic         ser_out;

   logic [W-1:0] m_sh, m_st;
   int checks = 0;
   int fails  = 0;

   dual_clk_sreg #(.W(W)) dut (
      .ser_in(ser_in), .sh_clk(sh_clk), .st_clk(st_clk),
      .sh_rst_n(sh_rst_n), .st_rst_n(st_rst_n),
      .par_out(par_out), .ser_out(ser_out)
   );

   task automatic chk(input string req, input logic [W-1:0] act, input logic [W-1:0] exp);
      checks++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s: actual %b expected %b at %0t", req, act, exp, $time);
      end
   endtask

   task automatic check_both(input string req);
      chk(req, par_out, m_st);
      chk(req, {{(W-1){1'b0}}, ser_out}, {{(W-1){1'b0}}, m_sh[W-1]});
   endtask

   // Drive one step: optional shift and/or store rising in the same instant
   task automatic step(input logic do_sh, input logic do_st, input logic d);
      ser_in = d;
      #HALF;
      if (do_st && st_rst_n) m_st = sh_rst_n ? m_sh : '0;
      if (do_sh && sh_rst_n) m_sh = {m_sh[W-2:0], d};
      if (do_sh) sh_clk = 1'b1;
      if (do_st) st_clk = 1'b1;
      #HALF;
      sh_clk = 1'b0;
      st_clk = 1'b0;
      #HALF;
   endtask

   initial begin : watchdog
      #(PERIOD * 20000);
      checks++;
      fails++;
      $display("FAIL watchdog: actual running expected finished");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
   end

   initial begin : main
      logic [W-1:0] held;
      logic         sv_ser;
      ser_in = 0; sh_clk = 0; st_clk = 0; sh_rst_n = 0; st_rst_n = 0;
      m_sh = '0; m_st = '0;
      #(PERIOD);
      check_both("R3 R4 reset state");
      sh_rst_n = 1; st_rst_n = 1;
      #(HALF);

      // Vector table walk: R1 R2 R5 R7 R9
      for (int i = 0; i < NV; i++) begin
         logic [1:0] op;
         op = VEC[i][2:1];
         step(op == 2'b00 || op == 2'b10, op == 2'b01 || op == 2'b10, VEC[i][0]);
         check_both(op == 2'b10 ? "R7 simultaneous" : (op == 2'b01 ? "R5 store" : "R1 R2 shift"));
      end

      // R9: one marked bit travels through W stages
      sh_rst_n = 0; #2; sh_rst_n = 1; m_sh = '0; #HALF;
      step(1, 0, 1'b1);
      for (int k = 1; k < W; k++) begin
         step(1, 0, 1'b0);
         chk("R9 latency", {{(W-1){1'b0}}, ser_out}, {{(W-1){1'b0}}, (k == W-1) ? 1'b1 : 1'b0});
      end

      // R3: shift reset clears shift only, parallel held
      for (int k = 0; k < W; k++) step(1, 0, 1'b1);
      step(0, 1, 1'b0);
      held = m_st;
      sh_rst_n = 0; m_sh = '0; #2;
      chk("R3 ser_out low", {{(W-1){1'b0}}, ser_out}, '0);
      chk("R3 par_out held", par_out, held);
      // R6: store while shift reset low loads zeros
      step(0, 1, 1'b1);
      chk("R6 zero load", par_out, '0);
      sh_rst_n = 1; #HALF;

      // R4: storage reset clears parallel only
      step(1, 0, 1'b1); step(1, 0, 1'b1); step(0, 1, 1'b0);
      for (int k = 0; k < W - 2; k++) step(1, 0, 1'b1);
      sv_ser = ser_out;
      st_rst_n = 0; m_st = '0; #2;
      chk("R4 par_out low", par_out, '0);
      chk("R4 ser_out kept", {{(W-1){1'b0}}, ser_out}, {{(W-1){1'b0}}, sv_ser});
      step(1, 0, 1'b0);
      chk("R4 shift during store reset", {{(W-1){1'b0}}, ser_out}, {{(W-1){1'b0}}, m_sh[W-1]});
      st_rst_n = 1; #HALF;

      // R8: storage leads shift by 2 ns -> old contents captured
      ser_in = 1'b0; #HALF;
      m_st = m_sh; m_sh = {m_sh[W-2:0], 1'b0};
      st_clk = 1; #2; sh_clk = 1; #3; st_clk = 0; #2; sh_clk = 0; #HALF;
      check_both("R8 storage first");
      // R8: shift between storage edges leaves outputs alone
      held = par_out;
      step(1, 0, 1'b1);
      chk("R8 par_out stable", par_out, held);
      // R8: shift leads storage by 2 ns -> new contents captured
      ser_in = 1'b1; #HALF;
      m_sh = {m_sh[W-2:0], 1'b1}; m_st = m_sh;
      sh_clk = 1; #2; st_clk = 1; #3; sh_clk = 0; #2; st_clk = 0; #HALF;
      check_both("R8 shift first");

      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
   end
endmodule